// File: doc/BRIEF.md
# Configurable UART Transceiver

This block is a full-duplex asynchronous serial transceiver set up through a small register port. Software picks the character length (7, 8 or 9 bits), optional parity with odd or even sense, one or two stop bits, and, for 8-bit characters only, whether the most significant bit goes first. The bit rate comes from a 2-bit prescaler select and an 8-bit divider. Each bit lasts sixteen divider ticks, and the receiver samples in the middle of each bit.

The transmitter has two stages: a holding register and a shift register. Software can therefore queue the next character while the current one is still on the line. Separate flags show when the holding register can take new data and when the shift register has gone idle. The receiver moves each finished character into a read buffer and raises a completion flag, which a read of the buffer clears. It reports overrun, framing and parity errors and also drives their OR as a summary flag.

The register port has no back-pressure. A write or a read completes in the cycle it is presented. Software uses the buffer-empty and receive-complete flags to pace its transfers.

Top module: `uart_xcvr`

## Requirements
- R1: Register map, two-bit address, 10-bit data. Address 0 write: transmit character in bits 8:0. Address 1 read: received character in bits 8:0. Address 2: divider value in bits 7:0 and prescaler select in bits 9:8. Address 3: configuration, with format code in bits 2:0, parity enable bit 3, odd parity bit 4, two stop bits bit 5, MSB first bit 6, open-drain bit 7, transmit enable bit 8, receive enable bit 9. Addresses 2 and 3 read back what was written, and both reset to zero.
- R2: Format code 3'b100 selects 7-bit characters, 3'b101 selects 8-bit and 3'b110 selects 9-bit. Any other code stops both serial engines: the line stays high, nothing is sent and nothing is received. A character already in the holding register is sent once a valid code is written.
- R3: A transmitted frame is a low start bit, then the data bits, then the parity bit if enabled, then one or two high stop bits. Even parity makes the count of ones in data plus parity even, and odd parity makes it odd. A bit lasts 16 × (divider + 1) × P clock cycles, where P is 1, 8, 32 or 64 for prescaler select 0, 1, 2 or 3.
- R4: With MSB first set and 8-bit characters, data bits go out and are taken in from bit 7 down to bit 0. For 7-bit and 9-bit characters the setting is ignored and the order is LSB first.
- R5: When no character is being shifted, `txd_out` is high. In push-pull mode `txd_oe` is always high. In open-drain mode `txd_oe` is low whenever the line is high and high while the line is low.
- R6: A character is moved from the holding register into the shift register only while transmit enable is 1. With the enable at 0, written data waits and the line stays idle.
- R7: `tx_buf_empty` goes low on a write to address 0 and returns high when the holding register moves into the shift register, which happens on the next clock if the shifter is idle. `tx_reg_empty` is low from that move until the last stop bit ends. A second write while a character is shifting stays queued and is sent right after the first.
- R8: The receiver accepts a start bit that is still low at mid-bit. When the first stop bit has been sampled, it stores the character in the read buffer, with unused upper bits read as zero, and sets `rx_done`. A read of address 1 clears `rx_done`.
- R9: If the first stop bit samples low, `err_frame` is set. The receiver then waits for the line to go high before it looks for a new start bit.
- R10: If parity is enabled and the received parity bit does not match the selected sense, `err_parity` is set.
- R11: If a character completes while `rx_done` is still set, `err_overrun` is set and the read buffer keeps its previous character.
- R12: `err_any` is high exactly when at least one of `err_overrun`, `err_frame` and `err_parity` is high.
- R13: While receive enable is 0, incoming frames are ignored and do not set `rx_done`. The three error flags clear on the clock after receive enable is seen at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 1 clears `rx_done` |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 10 | Write data |
| reg_rdata | output | 10 | Read data for `reg_addr`, combinational |
| rxd_in | input | 1 | Serial receive input, asynchronous |
| txd_out | output | 1 | Serial transmit level |
| txd_oe | output | 1 | Output enable for the transmit pin |
| tx_buf_empty | output | 1 | Holding register can accept a character |
| tx_reg_empty | output | 1 | No character is being shifted |
| rx_done | output | 1 | Read buffer holds an unread character |
| err_overrun | output | 1 | Overrun error |
| err_frame | output | 1 | Framing error |
| err_parity | output | 1 | Parity error |
| err_any | output | 1 | OR of the three error flags |

## Verification
Random character lengths, parity settings, stop-bit counts and bit orders are sent in loopback. The bench decodes every frame from the line and also reads it back through the receiver. A wrong bit order, a wrong parity sense or a bit period of the wrong length would show up as a wrong character or a spurious error. A back-to-back pair of writes checks the double buffer. A design that dropped or overwrote the queued character, or that overwrote the read buffer on overrun, would return the second character instead of the first. Directed frames with a low stop bit and with bad parity check the framing and parity flags, and the bench then confirms that turning off receive enable clears them. Further cases keep data in the holding register with transmit disabled, select an invalid format code, and select open drain. A design that sent anyway, or drove the pin while idle, would be caught.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

  localparam int REG_W    = 10;
  localparam int CHAR_W   = 9;
  localparam int FRAME_W  = 13;
  localparam int RBITS_W  = CHAR_W + 1;

  typedef struct packed {
    logic       msb_first;
    logic       stop2;
    logic       par_odd;
    logic       par_en;
    logic [2:0] mode;
  } fmt_t;

  typedef struct packed {
    logic rx_en;
    logic tx_en;
    logic od;
    fmt_t fmt;
  } cfg_t;

  function automatic logic [3:0] char_len(input logic [2:0] m);
    case (m)
      3'b100:  return 4'd7;
      3'b101:  return 4'd8;
      3'b110:  return 4'd9;
      default: return 4'd0;
    endcase
  endfunction

  // Masks to the character length and reverses 8-bit characters if requested.
  function automatic logic [CHAR_W-1:0] order_bits(input logic [CHAR_W-1:0] d,
                                                   input logic [3:0] len,
                                                   input logic msb);
    logic [CHAR_W-1:0] o;
    o = '0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < int'(len)) begin
        if (msb && len == 4'd8 && i < 8) o[i] = d[7-i];
        else                             o[i] = d[i];
      end
    end
    return o;
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic [CHAR_W-1:0] d,
                                                     input fmt_t f);
    logic [FRAME_W-1:0] fr;
    logic [CHAR_W-1:0]  ob;
    logic [3:0]         len;
    len = char_len(f.mode);
    ob  = order_bits(d, len, f.msb_first);
    fr  = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < int'(len)) fr[1+i] = ob[i];
    end
    if (f.par_en) fr[1+int'(len)] = (^ob) ^ f.par_odd;
    return fr;
  endfunction

  function automatic logic [3:0] frame_len(input fmt_t f);
    return 4'd2 + char_len(f.mode) + {3'b0, f.par_en} + {3'b0, f.stop2};
  endfunction

  function automatic logic [CHAR_W-1:0] unpack_char(input logic [RBITS_W-1:0] rb,
                                                    input logic [3:0] len,
                                                    input logic msb);
    logic [CHAR_W-1:0] raw;
    raw = '0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < int'(len)) raw[i] = rb[i];
    end
    return order_bits(raw, len, msb);
  endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       psel,
  input  logic [DIV_W-1:0] div,
  output logic             tick16
);
  localparam int PW = 6;

  logic [PW-1:0]    pcnt;
  logic [PW-1:0]    plim;
  logic [DIV_W-1:0] bcnt;
  logic             ptick;

  always_comb begin
    case (psel)
      2'd0:    plim = PW'(0);
      2'd1:    plim = PW'(7);
      2'd2:    plim = PW'(31);
      default: plim = PW'(63);
    endcase
  end

  assign ptick  = (pcnt == plim);
  assign tick16 = run && ptick && (bcnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      bcnt <= '0;
    end else if (!run) begin
      pcnt <= '0;
      bcnt <= '0;
    end else if (ptick) begin
      pcnt <= '0;
      bcnt <= (bcnt == div) ? '0 : bcnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_xcvr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tx_en,
  input  fmt_t              fmt,
  input  logic              tick16,
  input  logic              wr,
  input  logic [CHAR_W-1:0] wdata,
  output logic              line,
  output logic              buf_empty,
  output logic              reg_empty
);
  logic [CHAR_W-1:0]  thr;
  logic               thr_full;
  logic               busy;
  logic [FRAME_W-1:0] sh;
  logic [3:0]         bits_left;
  logic [3:0]         sub;
  logic               load;

  assign load = run && tx_en && thr_full && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr       <= '0;
      thr_full  <= 1'b0;
      busy      <= 1'b0;
      sh        <= '1;
      bits_left <= '0;
      sub       <= '0;
    end else begin
      if (!run) begin
        busy <= 1'b0;
        sh   <= '1;
      end else if (load) begin
        sh        <= build_frame(thr, fmt);
        bits_left <= frame_len(fmt);
        sub       <= '0;
        busy      <= 1'b1;
        thr_full  <= 1'b0;
      end else if (busy && tick16) begin
        if (sub == 4'd15) begin
          sub       <= '0;
          sh        <= {1'b1, sh[FRAME_W-1:1]};
          bits_left <= bits_left - 1'b1;
          if (bits_left == 4'd1) busy <= 1'b0;
        end else begin
          sub <= sub + 1'b1;
        end
      end
      if (wr) begin
        thr      <= wdata;
        thr_full <= 1'b1;
      end
    end
  end

  assign line      = busy ? sh[0] : 1'b1;
  assign buf_empty = !thr_full;
  assign reg_empty = !busy;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_xcvr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rx_en,
  input  logic [3:0]        len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              msb,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              rd_ack,
  output logic [CHAR_W-1:0] data,
  output logic              done,
  output logic              ovr,
  output logic              fe,
  output logic              pe
);
  logic [SYNC_STAGES-1:0] syn;
  logic                   rx_s;
  logic                   active;
  logic                   wait_hi;
  logic [3:0]             sub;
  logic [3:0]             bidx;
  logic [RBITS_W-1:0]     rbits;
  logic [3:0]             last_idx;
  logic                   complete;
  logic [CHAR_W-1:0]      decoded;
  logic                   par_bad;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syn <= '1;
        else        syn <= rxd;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syn <= '1;
        else        syn <= {syn[SYNC_STAGES-2:0], rxd};
      end
    end
  endgenerate

  assign rx_s     = syn[SYNC_STAGES-1];
  assign last_idx = len + {3'b0, par_en} + 4'd1;
  assign complete = run && rx_en && active && tick16 && (sub == 4'd7) && (bidx == last_idx);
  assign decoded  = unpack_char(rbits, len, msb);
  assign par_bad  = par_en && (((^decoded) ^ rbits[len]) != par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      wait_hi <= 1'b0;
      sub     <= '0;
      bidx    <= '0;
      rbits   <= '0;
    end else if (!run || !rx_en) begin
      active  <= 1'b0;
      wait_hi <= 1'b0;
    end else if (!active) begin
      if (wait_hi) begin
        if (rx_s) wait_hi <= 1'b0;
      end else if (!rx_s) begin
        active <= 1'b1;
        sub    <= '0;
        bidx   <= '0;
      end
    end else if (tick16) begin
      sub <= sub + 1'b1;
      if (sub == 4'd7) begin
        if (bidx == 4'd0) begin
          if (rx_s) active <= 1'b0;
          else      bidx   <= 4'd1;
        end else if (bidx == last_idx) begin
          active  <= 1'b0;
          wait_hi <= !rx_s;
        end else begin
          rbits[bidx - 4'd1] <= rx_s;
          bidx               <= bidx + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      done <= 1'b0;
      ovr  <= 1'b0;
      fe   <= 1'b0;
      pe   <= 1'b0;
    end else begin
      if (!rx_en) begin
        ovr <= 1'b0;
        fe  <= 1'b0;
        pe  <= 1'b0;
      end else if (complete) begin
        if (done && !rd_ack) begin
          ovr <= 1'b1;
        end else begin
          data <= decoded;
          done <= 1'b1;
          fe   <= fe | !rx_s;
          pe   <= pe | par_bad;
        end
      end
      if (rd_ack && !complete) done <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             rxd_in,
  output logic             txd_out,
  output logic             txd_oe,
  output logic             tx_buf_empty,
  output logic             tx_reg_empty,
  output logic             rx_done,
  output logic             err_overrun,
  output logic             err_frame,
  output logic             err_parity,
  output logic             err_any
);
  localparam logic [1:0] A_TXD = 2'd0;
  localparam logic [1:0] A_RXD = 2'd1;
  localparam logic [1:0] A_BRG = 2'd2;
  localparam logic [1:0] A_CFG = 2'd3;

  cfg_t              cfg_q;
  logic [DIV_W-1:0]  div_q;
  logic [1:0]        psel_q;
  logic              engine_on;
  logic              tick16;
  logic              tx_line;
  logic              tx_en_w;
  logic              rx_en_w;
  logic              od_w;
  logic [3:0]        len_w;
  logic [CHAR_W-1:0] rx_buf;
  logic              rd_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      div_q  <= '0;
      psel_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CFG) cfg_q <= cfg_t'(reg_wdata[$bits(cfg_t)-1:0]);
      if (reg_addr == A_BRG) begin
        div_q  <= reg_wdata[DIV_W-1:0];
        psel_q <= reg_wdata[REG_W-1:REG_W-2];
      end
    end
  end

  assign len_w     = char_len(cfg_q.fmt.mode);
  assign engine_on = (len_w != 4'd0);
  assign tx_en_w   = cfg_q.tx_en;
  assign rx_en_w   = cfg_q.rx_en;
  assign od_w      = cfg_q.od;
  assign rd_ack    = reg_rd && (reg_addr == A_RXD);

  uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (engine_on),
    .psel   (psel_q),
    .div    (div_q),
    .tick16 (tick16)
  );

  uart_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (engine_on),
    .tx_en     (tx_en_w),
    .fmt       (cfg_q.fmt),
    .tick16    (tick16),
    .wr        (reg_wr && reg_addr == A_TXD),
    .wdata     (reg_wdata[CHAR_W-1:0]),
    .line      (tx_line),
    .buf_empty (tx_buf_empty),
    .reg_empty (tx_reg_empty)
  );

  uart_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (engine_on),
    .rx_en   (rx_en_w),
    .len     (len_w),
    .par_en  (cfg_q.fmt.par_en),
    .par_odd (cfg_q.fmt.par_odd),
    .msb     (cfg_q.fmt.msb_first),
    .tick16  (tick16),
    .rxd     (rxd_in),
    .rd_ack  (rd_ack),
    .data    (rx_buf),
    .done    (rx_done),
    .ovr     (err_overrun),
    .fe      (err_frame),
    .pe      (err_parity)
  );

  assign txd_out = tx_line;
  assign txd_oe  = od_w ? !tx_line : 1'b1;
  assign err_any = err_overrun | err_frame | err_parity;

  always_comb begin
    case (reg_addr)
      A_RXD:   reg_rdata = REG_W'(rx_buf);
      A_BRG:   reg_rdata = REG_W'({psel_q, div_q});
      A_CFG:   reg_rdata = REG_W'(cfg_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       engine_on,
  input logic       tx_en,
  input logic       rx_en,
  input logic       od,
  input logic       txd_out,
  input logic       txd_oe,
  input logic       tx_buf_empty,
  input logic       tx_reg_empty,
  input logic       rx_done,
  input logic [8:0] rx_buf,
  input logic       err_overrun,
  input logic       err_frame,
  input logic       err_parity,
  input logic       err_any
);
  // R2: an invalid format code empties the shifter
  a_r2_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !engine_on |=> tx_reg_empty);

  // R5: idle line is high
  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reg_empty |-> txd_out);

  // R5: open drain releases the idle line
  a_r5_od_release: assert property (@(posedge clk) disable iff (!rst_n)
    (od && tx_reg_empty) |-> !txd_oe);

  // R6: disabled transmitter never starts
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && tx_reg_empty) |=> tx_reg_empty);

  // R7: buffer empties only by moving into the shifter
  a_r7_move: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_buf_empty) |-> !tx_reg_empty);

  // R11: overrun keeps the old character
  a_r11_keep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> (rx_done && $stable(rx_buf)));

  // R12: summary rises with one of its sources
  a_r12_summary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_any) |-> ($rose(err_overrun) || $rose(err_frame) || $rose(err_parity)));

  // R13: receive disable clears errors
  a_r13_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !err_any);
endmodule

bind uart_xcvr uart_xcvr_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .engine_on    (engine_on),
  .tx_en        (tx_en_w),
  .rx_en        (rx_en_w),
  .od           (od_w),
  .txd_out      (txd_out),
  .txd_oe       (txd_oe),
  .tx_buf_empty (tx_buf_empty),
  .tx_reg_empty (tx_reg_empty),
  .rx_done      (rx_done),
  .rx_buf       (rx_buf),
  .err_overrun  (err_overrun),
  .err_frame    (err_frame),
  .err_parity   (err_parity),
  .err_any      (err_any)
);

// File: tb/uart_xcvr_tb.sv
module uart_xcvr_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [9:0] reg_wdata;
  logic [9:0] reg_rdata;
  logic       rxd_in, txd_out, txd_oe;
  logic       tx_buf_empty, tx_reg_empty, rx_done;
  logic       err_overrun, err_frame, err_parity, err_any;
  logic       loop_en, rx_drv;
  int         n_chk = 0;
  int         n_fail = 0;
  int         bitlen = 32;

  always #4 clk = ~clk;

  assign rxd_in = loop_en ? txd_out : rx_drv;

  uart_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxd_in(rxd_in), .txd_out(txd_out), .txd_oe(txd_oe),
    .tx_buf_empty(tx_buf_empty), .tx_reg_empty(tx_reg_empty), .rx_done(rx_done),
    .err_overrun(err_overrun), .err_frame(err_frame), .err_parity(err_parity),
    .err_any(err_any)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish act=0 exp=1");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int mode_len(input int m);
    return (m == 4) ? 7 : (m == 5) ? 8 : 9;
  endfunction

  function automatic logic [9:0] cfgw(input int m, input bit pe, input bit po,
                                      input bit s2, input bit msb, input bit od,
                                      input bit te, input bit re);
    logic [2:0] mm;
    mm = 3'(m);
    return {re, te, od, msb, s2, po, pe, mm};
  endfunction

  function automatic void exp_frame(input logic [8:0] d, input int len, input bit pe,
                                    input bit po, input bit s2, input bit msb,
                                    output logic [15:0] f, output int n);
    logic p;
    f = '1;
    n = 0;
    f[n] = 1'b0; n++;
    for (int i = 0; i < len; i++) begin
      f[n] = (msb && len == 8) ? d[7-i] : d[i];
      n++;
    end
    if (pe) begin
      p = po;
      for (int i = 0; i < len; i++) p = p ^ d[i];
      f[n] = p; n++;
    end
    f[n] = 1'b1; n++;
    if (s2) begin f[n] = 1'b1; n++; end
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [9:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic capture_tx(input int n, output logic [15:0] got);
    int t;
    got = '1;
    t = 0;
    while (txd_out !== 1'b0 && t < 20 * bitlen) begin
      @(negedge clk); t++;
    end
    check(txd_out === 1'b0, "R3", "start bit seen", int'(txd_out), 0);
    repeat (bitlen / 2) @(negedge clk);
    got[0] = txd_out;
    for (int i = 1; i < n; i++) begin
      repeat (bitlen) @(negedge clk);
      got[i] = txd_out;
    end
  endtask

  task automatic send_rx(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_drv = bits[i];
      repeat (bitlen - 1) @(negedge clk);
    end
    rx_drv = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle_watch(input int cycles, output bit saw_low);
    saw_low = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd_out !== 1'b1) saw_low = 1'b1;
    end
  endtask

  initial begin
    logic [15:0] ef, got;
    logic [9:0]  rd;
    logic [8:0]  d, d2;
    int          n, m, len, seed;
    bit          pe, po, s2, msb, low;

    seed = int'($urandom(32'h1a2b));
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    loop_en = 1'b1; rx_drv = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(txd_out === 1'b1 && txd_oe === 1'b1, "R5", "reset line", int'({txd_out, txd_oe}), 3);
    check(tx_buf_empty === 1'b1 && tx_reg_empty === 1'b1, "R7", "reset tx flags",
          int'({tx_buf_empty, tx_reg_empty}), 3);
    check(rx_done === 1'b0 && err_any === 1'b0, "R8", "reset rx flags", int'({rx_done, err_any}), 0);
    bus_rd(2'd3, rd);
    check(rd == 10'h0, "R1", "reset cfg", int'(rd), 0);

    bus_wr(2'd2, {2'b00, 8'd1});
    bus_rd(2'd2, rd);
    check(rd == 10'h001, "R1", "divider readback", int'(rd), 1);

    // random loopback frames
    for (int it = 0; it < 14; it++) begin
      m   = 4 + int'($urandom_range(2, 0));
      len = mode_len(m);
      pe  = 1'($urandom); po = 1'($urandom); s2 = 1'($urandom); msb = 1'($urandom);
      d   = 9'($urandom);
      bus_wr(2'd3, cfgw(m, pe, po, s2, msb, 1'b0, 1'b1, 1'b1));
      bus_rd(2'd3, rd);
      check(rd == cfgw(m, pe, po, s2, msb, 1'b0, 1'b1, 1'b1), "R1", "cfg readback", int'(rd),
            int'(cfgw(m, pe, po, s2, msb, 1'b0, 1'b1, 1'b1)));
      bus_wr(2'd0, {1'b0, d});
      check(tx_buf_empty === 1'b0, "R7", "buffer full after write", int'(tx_buf_empty), 0);
      @(negedge clk);
      check(tx_buf_empty === 1'b1 && tx_reg_empty === 1'b0, "R7", "moved to shifter",
            int'({tx_buf_empty, tx_reg_empty}), 2);
      exp_frame(d, len, pe, po, s2, msb, ef, n);
      capture_tx(n, got);
      check(got == ef, (msb && len != 8) ? "R4" : "R3", "tx frame", int'(got), int'(ef));
      repeat (bitlen) @(negedge clk);
      check(tx_reg_empty === 1'b1, "R7", "shifter empty after frame", int'(tx_reg_empty), 1);
      check(rx_done === 1'b1 && err_any === 1'b0, "R8", "loopback received clean",
            int'({rx_done, err_any}), 2);
      bus_rd(2'd1, rd);
      check(rd == 10'(d & 9'((1 << len) - 1)), "R8", "received data masked", int'(rd),
            int'(d & 9'((1 << len) - 1)));
      check(rx_done === 1'b0, "R8", "read clears done", int'(rx_done), 0);
    end

    // double buffer and overrun
    bus_wr(2'd3, cfgw(5, 0, 0, 0, 0, 0, 1, 1));
    d = 9'h0a5; d2 = 9'h03c;
    bus_wr(2'd0, {1'b0, d});
    bus_wr(2'd0, {1'b0, d2});
    check(tx_buf_empty === 1'b0 && tx_reg_empty === 1'b0, "R7", "second write queued",
          int'({tx_buf_empty, tx_reg_empty}), 0);
    exp_frame(d, 8, 0, 0, 0, 0, ef, n);
    capture_tx(n, got);
    check(got == ef, "R7", "first of pair", int'(got), int'(ef));
    exp_frame(d2, 8, 0, 0, 0, 0, ef, n);
    capture_tx(n, got);
    check(got == ef, "R7", "second of pair", int'(got), int'(ef));
    repeat (bitlen) @(negedge clk);
    check(err_overrun === 1'b1, "R11", "overrun set", int'(err_overrun), 1);
    check(err_any === 1'b1, "R12", "summary on overrun", int'(err_any), 1);
    bus_rd(2'd1, rd);
    check(rd == 10'h0a5, "R11", "old data kept", int'(rd), 'h0a5);

    // receive disable clears errors and ignores frames
    bus_wr(2'd3, cfgw(5, 0, 0, 0, 0, 0, 1, 0));
    @(negedge clk);
    check(err_any === 1'b0 && err_overrun === 1'b0, "R13", "errors cleared", int'(err_any), 0);
    bus_wr(2'd0, 10'h055);
    exp_frame(9'h055, 8, 0, 0, 0, 0, ef, n);
    capture_tx(n, got);
    repeat (bitlen) @(negedge clk);
    check(rx_done === 1'b0, "R13", "frame ignored while disabled", int'(rx_done), 0);

    // transmit enable gating
    bus_wr(2'd3, cfgw(5, 0, 0, 0, 0, 0, 0, 1));
    bus_wr(2'd0, 10'h0c3);
    idle_watch(3 * bitlen, low);
    check(!low && tx_reg_empty === 1'b1, "R6", "no start while disabled", int'(low), 0);
    check(tx_buf_empty === 1'b0, "R6", "data waits in buffer", int'(tx_buf_empty), 0);
    bus_wr(2'd3, cfgw(5, 0, 0, 0, 0, 0, 1, 1));
    exp_frame(9'h0c3, 8, 0, 0, 0, 0, ef, n);
    capture_tx(n, got);
    check(got == ef, "R6", "sent after enable", int'(got), int'(ef));
    repeat (bitlen) @(negedge clk);
    bus_rd(2'd1, rd);

    // invalid format code
    loop_en = 1'b0;
    bus_wr(2'd3, cfgw(3, 0, 0, 0, 0, 0, 1, 1));
    bus_wr(2'd0, 10'h1e7);
    idle_watch(3 * bitlen, low);
    check(!low && tx_reg_empty === 1'b1, "R2", "invalid code idle", int'(low), 0);
    exp_frame(9'h05a, 8, 0, 0, 0, 0, ef, n);
    send_rx(ef, n);
    check(rx_done === 1'b0, "R2", "invalid code no receive", int'(rx_done), 0);
    bus_wr(2'd3, cfgw(6, 0, 0, 0, 0, 0, 1, 1));
    exp_frame(9'h1e7, 9, 0, 0, 0, 0, ef, n);
    capture_tx(n, got);
    check(got == ef, "R2", "held data sent in 9-bit", int'(got), int'(ef));
    repeat (bitlen) @(negedge clk);

    // open drain
    bus_wr(2'd3, cfgw(5, 0, 0, 0, 0, 1, 1, 1));
    check(txd_oe === 1'b0 && txd_out === 1'b1, "R5", "open drain idle released",
          int'({txd_out, txd_oe}), 2);
    bus_wr(2'd0, 10'h0f0);
    @(negedge clk);
    check(txd_oe === 1'b1 && txd_out === 1'b0, "R5", "open drain drives start",
          int'({txd_out, txd_oe}), 1);
    while (tx_reg_empty !== 1'b1) @(negedge clk);
    bus_wr(2'd3, cfgw(5, 0, 0, 0, 0, 0, 1, 1));

    // framing error
    ef = 16'h0000; ef[0] = 0; ef[8:1] = 8'h69; ef[9] = 1'b0;
    send_rx(ef, 10);
    check(err_frame === 1'b1 && err_any === 1'b1, "R9", "framing error",
          int'({err_frame, err_any}), 3);
    bus_rd(2'd1, rd);
    check(rd == 10'h069, "R9", "data with bad stop", int'(rd), 'h69);
    repeat (2 * bitlen) @(negedge clk);
    check(rx_done === 1'b0, "R9", "no false start after low stop", int'(rx_done), 0);
    bus_wr(2'd3, cfgw(4, 1, 0, 0, 0, 0, 1, 0));
    bus_wr(2'd3, cfgw(4, 1, 0, 0, 0, 0, 1, 1));
    check(err_any === 1'b0, "R13", "frame error cleared", int'(err_any), 0);

    // parity error, 7-bit even
    exp_frame(9'h033, 7, 1, 0, 0, 0, ef, n);
    ef[8] = ~ef[8];
    send_rx(ef, n);
    check(err_parity === 1'b1 && err_frame === 1'b0, "R10", "parity error",
          int'({err_parity, err_frame}), 2);
    check(err_any === 1'b1, "R12", "summary on parity", int'(err_any), 1);
    bus_rd(2'd1, rd);
    check(rd == 10'h033, "R10", "data with bad parity", int'(rd), 'h33);

    // prescaler /8, divider 0: 128 clocks per bit
    loop_en = 1'b1;
    bus_wr(2'd3, cfgw(5, 0, 0, 0, 0, 0, 1, 0));
    bus_wr(2'd2, {2'b01, 8'd0});
    bitlen = 128;
    bus_wr(2'd0, 10'h096);
    exp_frame(9'h096, 8, 0, 0, 0, 0, ef, n);
    capture_tx(n, got);
    check(got == ef, "R3", "prescaled bit period", int'(got), int'(ef));
    repeat (bitlen) @(negedge clk);

    summary();
    $finish;
  end
endmodule